// File: doc/BRIEF.md
# Supervisory Reset Pulse Generator

This block turns two digital reset conditions into a clean processor reset. One condition is a supply-low flag from an external voltage comparator. The other is an active-low manual reset request, which may come from a push button or from another logic output. Both inputs are asynchronous to the system clock, so each passes through a two-flop synchroniser before the control logic sees it.

Reset is asserted for as long as either condition is present. Once the last condition clears, reset stays asserted for a fixed hold period measured in milliseconds. A prescaler derives the millisecond timebase from the system clock. Every manual release and every supply recovery restarts the same hold timer. That timer is also the only debounce the manual input gets: contact bounce keeps reloading it, and reset releases only after the input has been quiet for the whole hold. The block's own synchronous reset preloads the hold timer, so the processor reset is asserted from the first clock edge and is released only after a full hold.

Two reset outputs are provided, one active-low and one active-high, and they are always complements. A one-cycle status pulse marks the cycle in which reset releases.

Top module: `reset_pulse_gen`

## Requirements
- R1: While the block's own reset `rst_n` is low, `rst_out_n` is low at every sampled clock.
- R2: After `rst_n` goes high with both sources idle, `rst_out_n` stays low and goes high after exactly HOLD_MS*CYC_PER_MS rising edges, counting the first edge that samples `rst_n` high.
- R3: While `supply_low` is high, `rst_out_n` stays low, beginning no later than the third rising edge after `supply_low` rises.
- R4: While `man_rst_n` is low, `rst_out_n` stays low, beginning no later than the third rising edge after `man_rst_n` falls.
- R5: When the last active source clears, `rst_out_n` goes high after exactly 2 + HOLD_MS*CYC_PER_MS rising edges: two for synchronisation and then the full hold.
- R6: Each return of `man_rst_n` to low during the hold restarts the hold. Reset releases only the full 2 + HOLD_MS*CYC_PER_MS edges after the final rising edge of `man_rst_n`.
- R7: When both sources overlap, the hold is timed from the source that clears last. Clearing the first source has no visible effect on `rst_out_n`.
- R8: `rst_out` is always the logical inverse of `rst_out_n`.
- R9: `rel_pulse` is high for exactly one cycle: the first cycle in which `rst_out_n` is high after being low. It is low at all other times.
- R10: A manual request held low for a single clock period still produces a full hold of 2 + HOLD_MS*CYC_PER_MS edges after its release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset of the block itself |
| supply_low | input | 1 | Supply-below-threshold flag from an external comparator, asynchronous |
| man_rst_n | input | 1 | Active-low manual reset request, asynchronous and possibly bouncing |
| rst_out_n | output | 1 | Processor reset, active low |
| rst_out | output | 1 | Processor reset, active high, the complement of rst_out_n |
| rel_pulse | output | 1 | One-cycle pulse when the processor reset releases |

## Verification
Faults in this block show up as release timing at the ports. If the prescaler or the hold counter is off by one, or a synchroniser stage is missing, the release moves by one or more cycles. The bench counts every edge from the stimulus to the release, so it catches this on the first hold it measures. If the hold does not reload, a bounce test releases early, within a few edges of the last bounce. A wrong reset preload shows up as an early release right after power-up. A stuck or doubled status pulse shows up in the cycle of release or in the cycle after it.

// File: rtl/rpg_pkg.sv
package rpg_pkg;
  // Synchronised view of the two reset sources
  typedef struct packed {
    logic man_n;   // manual request, active low
    logic low;     // supply-low flag, active high
  } rpg_src_t;

  localparam rpg_src_t RPG_SRC_IDLE = '{man_n: 1'b1, low: 1'b0};
endpackage

// File: rtl/rpg_sync.sv
module rpg_sync #(
  parameter int unsigned WIDTH = 2,
  parameter logic [WIDTH-1:0] IDLE_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic meta_q, sync_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        meta_q <= IDLE_VAL[g];
        sync_q <= IDLE_VAL[g];
      end else begin
        meta_q <= d_async[g];
        sync_q <= meta_q;
      end
    end
    assign q_sync[g] = sync_q;
  end
endmodule

// File: rtl/rpg_tick_gen.sv
module rpg_tick_gen #(
  parameter int unsigned CYC_PER_MS = 50000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);
  localparam int unsigned CW = (CYC_PER_MS > 1) ? $clog2(CYC_PER_MS) : 1;
  localparam logic [CW-1:0] LAST = CW'(CYC_PER_MS - 1);

  logic [CW-1:0] pre_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr)      pre_q <= '0;
    else if (pre_q == LAST) pre_q <= '0;
    else                    pre_q <= pre_q + 1'b1;
  end

  assign tick = (pre_q == LAST) && !clr;

  a_r2_prescale_range: assert property (@(posedge clk) disable iff (!rst_n)
    pre_q <= LAST);
  a_r5_clear_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (pre_q == '0));
endmodule

// File: rtl/rpg_hold_ctr.sv
module rpg_hold_ctr #(
  parameter int unsigned HOLD_MS = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic tick,
  output logic busy
);
  localparam int unsigned HW = $clog2(HOLD_MS + 1);
  localparam logic [HW-1:0] FULL = HW'(HOLD_MS);

  logic [HW-1:0] ms_q;

  always_ff @(posedge clk) begin
    if (!rst_n || load)        ms_q <= FULL;
    else if (tick && ms_q != 0) ms_q <= ms_q - 1'b1;
  end

  assign busy = (ms_q != '0);

  a_r5_never_above_full: assert property (@(posedge clk) disable iff (!rst_n)
    ms_q <= FULL);
  a_r6_load_reloads: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (ms_q == FULL));
  a_r5_steps_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(load) && $past(busy) |-> (ms_q == $past(ms_q)) || (ms_q == $past(ms_q) - 1'b1));
endmodule

// File: rtl/reset_pulse_gen.sv
module reset_pulse_gen
  import rpg_pkg::*;
#(
  parameter int unsigned CYC_PER_MS = 50000,
  parameter int unsigned HOLD_MS    = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_low,
  input  logic man_rst_n,
  output logic rst_out_n,
  output logic rst_out,
  output logic rel_pulse
);
  rpg_src_t src_raw, src_s;
  logic     any_src, tick, busy, asserted, asserted_q;

  assign src_raw = '{man_n: man_rst_n, low: supply_low};

  rpg_sync #(.WIDTH(2), .IDLE_VAL(RPG_SRC_IDLE)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(src_raw), .q_sync(src_s)
  );

  assign any_src = src_s.low || !src_s.man_n;

  rpg_tick_gen #(.CYC_PER_MS(CYC_PER_MS)) u_tick (
    .clk(clk), .rst_n(rst_n), .clr(any_src), .tick(tick)
  );

  rpg_hold_ctr #(.HOLD_MS(HOLD_MS)) u_hold (
    .clk(clk), .rst_n(rst_n), .load(any_src), .tick(tick), .busy(busy)
  );

  assign asserted = any_src || busy;

  always_ff @(posedge clk) begin
    if (!rst_n) asserted_q <= 1'b1;
    else        asserted_q <= asserted;
  end

  assign rst_out_n = !asserted;
  assign rst_out   = asserted;
  assign rel_pulse = asserted_q && !asserted;

  a_r3_low_holds_reset: assert property (@(posedge clk) disable iff (!rst_n)
    supply_low && $past(supply_low) |=> !rst_out_n);
  a_r4_manual_holds_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !man_rst_n && !$past(man_rst_n) |=> !rst_out_n);
  a_r8_outputs_complement: assert property (@(posedge clk) disable iff (!rst_n)
    rst_out != rst_out_n);
  a_r9_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    rel_pulse |=> !rel_pulse);
  a_r9_pulse_on_release: assert property (@(posedge clk) disable iff (!rst_n)
    rel_pulse |-> rst_out_n && !$past(rst_out_n));
endmodule

// File: tb/reset_pulse_gen_tb_top.sv
module reset_pulse_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CPM  = 4;
  localparam int HOLD = 5;
  localparam int HC   = CPM * HOLD;

  logic clk = 1'b0;
  logic rst_n, supply_low, man_rst_n;
  logic rst_out_n, rst_out, rel_pulse;
  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  reset_pulse_gen #(.CYC_PER_MS(CPM), .HOLD_MS(HOLD)) dut_i (
    .clk(clk), .rst_n(rst_n), .supply_low(supply_low), .man_rst_n(man_rst_n),
    .rst_out_n(rst_out_n), .rst_out(rst_out), .rel_pulse(rel_pulse)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // R8/R9 observed each cycle while held
  task automatic expect_held(input string req, input int cycles);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      check(req, rst_out_n, 0);
      check("R8", rst_out, 1);
      check("R9", rel_pulse, 0);
    end
  endtask

  // Count rising edges from now until rst_out_n is seen high
  task automatic measure_release(input string req, input int exp);
    int cnt = 0;
    for (int i = 0; i < 4 * HC; i++) begin
      @(posedge clk);
      cnt++;
      @(negedge clk);
      if (rst_out_n) break;
      check("R8", rst_out, 1);
      check("R9", rel_pulse, 0);
    end
    check(req, cnt, exp);
    check("R9", rel_pulse, 1);
    check("R8", rst_out, 0);
    @(negedge clk);
    check("R9", rel_pulse, 0);
    check(req, rst_out_n, 1);
  endtask

  task automatic t_power_up();
    rst_n = 1'b0; supply_low = 1'b0; man_rst_n = 1'b1;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R1", rst_out_n, 0);
      check("R8", rst_out, 1);
    end
    rst_n = 1'b1;
    measure_release("R2", HC);
  endtask

  task automatic t_supply_low();
    supply_low = 1'b1;
    @(negedge clk); @(negedge clk); @(negedge clk);
    check("R3", rst_out_n, 0);
    expect_held("R3", 2 * HC);
    supply_low = 1'b0;
    measure_release("R5", HC + 2);
  endtask

  task automatic t_manual();
    man_rst_n = 1'b0;
    @(negedge clk); @(negedge clk); @(negedge clk);
    check("R4", rst_out_n, 0);
    expect_held("R4", HC + 7);
    man_rst_n = 1'b1;
    measure_release("R5", HC + 2);
  endtask

  task automatic t_bounce();
    man_rst_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int b = 0; b < 4; b++) begin
      man_rst_n = 1'b1;
      expect_held("R6", HC - 3);
      man_rst_n = 1'b0;
      repeat (2) @(negedge clk);
    end
    man_rst_n = 1'b1;
    measure_release("R6", HC + 2);
  endtask

  task automatic t_overlap();
    supply_low = 1'b1;
    repeat (3) @(negedge clk);
    man_rst_n = 1'b0;
    repeat (5) @(negedge clk);
    supply_low = 1'b0;
    expect_held("R7", HC + 10);
    man_rst_n = 1'b1;
    measure_release("R7", HC + 2);
    man_rst_n = 1'b0;
    repeat (5) @(negedge clk);
    supply_low = 1'b1;
    repeat (3) @(negedge clk);
    man_rst_n = 1'b1;
    expect_held("R7", HC + 10);
    supply_low = 1'b0;
    measure_release("R7", HC + 2);
  endtask

  task automatic t_short_request();
    man_rst_n = 1'b0;
    @(negedge clk);
    man_rst_n = 1'b1;
    measure_release("R10", HC + 2);
    expect_idle();
  endtask

  task automatic expect_idle();
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check("R9", rel_pulse, 0);
      check("R8", rst_out, 0);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; supply_low = 1'b0; man_rst_n = 1'b1;
    t_power_up();
    t_supply_low();
    t_manual();
    t_bounce();
    t_overlap();
    t_short_request();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule